// File: doc/BRIEF.md
# Power-of-Two Clock Divider Bank with Ratio Enforcement

This block derives six domain clock enables from one parent clock: processor core, signal-processor core, signal-processor memory management, traffic controller, peripheral bus and display controller. Each domain divides the parent by 1, 2, 4 or 8, selected by a 2-bit exponent held in a 16-bit control word. All six dividers read one shared free-running phase counter. Every derived tick therefore lands on a common parent edge. Each domain output is a one-cycle tick that downstream logic uses as a clock enable.

Software-side writes go to a shadow word. A write is either a whole new word or a change to one domain's field. Before the shadow word is stored, a correction stage forces the ratio rules between domains to hold. The corrected shadow is copied into the active word only at the edge where the phase counter wraps. All dividers therefore switch together, and no divider ever sees a word that breaks the rules. A combinational helper turns a target rate into the smallest exponent whose result does not exceed it. A report port returns the rate each domain runs at under the active word.

Field layout of the control word (exponent e, 2 bits per domain): bits [1:0] core, [3:2] signal processor, [5:4] its memory management unit, [7:6] traffic controller, [9:8] peripheral, [11:10] display. Domain select codes follow the same order, 0 to 5. Bits [15:12] are not stored.

Top module: `pow2_div_bank`

## Requirements
- R1: After reset the active and shadow words are 0x0000. The phase counter starts at 0, so every enabled domain ticks in the first cycle after reset.
- R2: A domain with active exponent e and its enable set ticks exactly when the low e bits of the shared 3-bit phase counter are zero. That is once every 2^e cycles, counting from reset, and all domains are aligned at counter value 0.
- R3: Correction first raises the memory-management exponent (bits [5:4]) to at least the signal-processor exponent (bits [3:2]). It then lowers it to at most that exponent plus one.
- R4: Correction then raises the traffic-controller exponent (bits [7:6]) to at least the core exponent (bits [1:0]). It then raises it again to at least the corrected memory-management exponent.
- R5: After the raises, the traffic-controller exponent is lowered to at most the display exponent (bits [11:10]), then to at most the peripheral exponent (bits [9:8]). When a floor and a ceiling conflict, the ceiling wins.
- R6: A field write (fld_en) replaces only the field chosen by fld_sel (0 to 5) in the current shadow word, then corrects the whole word. A fld_sel of 6 or 7 leaves the shadow unchanged. When wr_en and fld_en are both high, the whole-word write wins.
- R7: The active word takes the shadow value only at a clock edge where the phase counter moves from 7 to 0. A write on that same edge reaches the active word one wrap later.
- R8: A low dom_en bit forces that domain's tick low. It does not stop or reset the shared counter, so the ticks stay phase-aligned when the enable returns.
- R9: hlp_exp is the smallest e in 0..3 with (parent_rate >> e) <= target_rate, and hlp_ok is high. If no such e exists, hlp_ok is low.
- R10: rate_out equals parent_rate shifted right by the active exponent of the domain chosen by rate_sel. It is zero for rate_sel 6 or 7.
- R11: Bits [15:12] of a written word are dropped: they read as zero in both the shadow and the active word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Whole-word write strobe |
| wr_word | input | 16 | Word to correct and store in the shadow |
| fld_en | input | 1 | Single-field write strobe |
| fld_sel | input | 3 | Domain whose field is replaced |
| fld_exp | input | 2 | New exponent for that field |
| dom_en | input | 6 | Per-domain tick enable |
| dom_tick | output | 6 | Per-domain divided tick |
| act_word | output | 16 | Active (committed) control word |
| shd_word | output | 16 | Corrected shadow word awaiting commit |
| parent_rate | input | 32 | Parent clock rate, any unit |
| target_rate | input | 32 | Requested rate for the helper |
| hlp_exp | output | 2 | Smallest fitting exponent |
| hlp_ok | output | 1 | A fitting exponent exists |
| rate_sel | input | 3 | Domain whose rate is reported |
| rate_out | output | 32 | Reported rate of that domain |

## Verification
The hardest case to reach from the ports is a write that arrives on the very edge where the phase counter wraps. On that edge the active word must take the older shadow value, and the new value must wait a full period. The counter is not visible at the ports. The stimulus therefore repeats a write after each of eight different idle delays, so that writes land at every counter phase, including the wrap edge. A cycle-exact model in the bench then flags any commit that comes one period early or late. Conflicting-rule words, where the display or peripheral ceiling sits below the core floor, are also written on purpose.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
   localparam int NUM_DOM = 6;
   localparam int IDX_CORE = 0;
   localparam int IDX_SP   = 1;
   localparam int IDX_MMU  = 2;
   localparam int IDX_TC   = 3;
   localparam int IDX_PER  = 4;
   localparam int IDX_DISP = 5;
   localparam int SEL_W    = $clog2(NUM_DOM);
endpackage

// File: rtl/ratio_fix.sv
module ratio_fix
   import pow2_div_pkg::*;
#(
   parameter int EXP_W  = 2,
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] raw_word,
   output logic [WORD_W-1:0] fixed_word
);
   localparam int XW = EXP_W + 1;

   logic [XW-1:0] ex [NUM_DOM];
   logic [XW-1:0] mmu_v;
   logic [XW-1:0] tc_v;

   always_comb begin
      for (int d = 0; d < NUM_DOM; d++) begin
         ex[d] = {1'b0, raw_word[d*EXP_W +: EXP_W]};
      end
      // memory-management exponent held within [sp, sp+1]
      mmu_v = ex[IDX_MMU];
      if (mmu_v < ex[IDX_SP]) mmu_v = ex[IDX_SP];
      if (mmu_v > ex[IDX_SP] + XW'(1)) mmu_v = ex[IDX_SP] + XW'(1);
      // traffic controller: floors first, ceilings last
      tc_v = ex[IDX_TC];
      if (tc_v < ex[IDX_CORE]) tc_v = ex[IDX_CORE];
      if (tc_v < mmu_v) tc_v = mmu_v;
      if (tc_v > ex[IDX_DISP]) tc_v = ex[IDX_DISP];
      if (tc_v > ex[IDX_PER]) tc_v = ex[IDX_PER];
      fixed_word = '0;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (d == IDX_MMU)
            fixed_word[d*EXP_W +: EXP_W] = mmu_v[EXP_W-1:0];
         else if (d == IDX_TC)
            fixed_word[d*EXP_W +: EXP_W] = tc_v[EXP_W-1:0];
         else
            fixed_word[d*EXP_W +: EXP_W] = ex[d][EXP_W-1:0];
      end
   end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt  = cnt_q;
   assign wrap = (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
   parameter int EXP_W = 2,
   parameter int CNT_W = 3
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [EXP_W-1:0] exp_i,
   input  logic             en,
   output logic             tick
);
   logic [CNT_W-1:0] mask;

   always_comb begin
      for (int b = 0; b < CNT_W; b++) begin
         mask[b] = (b < int'(exp_i));
      end
   end

   assign tick = en && ((cnt & mask) == '0);
endmodule

// File: rtl/rate_unit.sv
module rate_unit
   import pow2_div_pkg::*;
#(
   parameter int EXP_W  = 2,
   parameter int WORD_W = 16,
   parameter int RATE_W = 32
) (
   input  logic [RATE_W-1:0] parent_rate,
   input  logic [RATE_W-1:0] target_rate,
   input  logic [WORD_W-1:0] act_word,
   input  logic [SEL_W-1:0]  rate_sel,
   output logic [EXP_W-1:0]  hlp_exp,
   output logic              hlp_ok,
   output logic [RATE_W-1:0] rate_out
);
   localparam int NUM_EXP = 1 << EXP_W;

   always_comb begin
      hlp_exp = '0;
      hlp_ok  = 1'b0;
      for (int e = NUM_EXP - 1; e >= 0; e--) begin
         if ((parent_rate >> e) <= target_rate) begin
            hlp_exp = EXP_W'(e);
            hlp_ok  = 1'b1;
         end
      end
   end

   always_comb begin
      rate_out = '0;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (int'(rate_sel) == d)
            rate_out = parent_rate >> act_word[d*EXP_W +: EXP_W];
      end
   end
endmodule

// File: rtl/pow2_div_bank.sv
module pow2_div_bank
   import pow2_div_pkg::*;
#(
   parameter int EXP_W  = 2,
   parameter int WORD_W = 16,
   parameter int RATE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              fld_en,
   input  logic [SEL_W-1:0]  fld_sel,
   input  logic [EXP_W-1:0]  fld_exp,
   input  logic [NUM_DOM-1:0] dom_en,
   output logic [NUM_DOM-1:0] dom_tick,
   output logic [WORD_W-1:0] act_word,
   output logic [WORD_W-1:0] shd_word,
   input  logic [RATE_W-1:0] parent_rate,
   input  logic [RATE_W-1:0] target_rate,
   output logic [EXP_W-1:0]  hlp_exp,
   output logic              hlp_ok,
   input  logic [SEL_W-1:0]  rate_sel,
   output logic [RATE_W-1:0] rate_out
);
   localparam int CNT_W = (1 << EXP_W) - 1;

   generate
      if (WORD_W < NUM_DOM * EXP_W) begin : g_bad_word
         $error("pow2_div_bank: WORD_W too small for all exponent fields");
      end
      if (EXP_W < 1 || EXP_W > 3) begin : g_bad_exp
         $error("pow2_div_bank: EXP_W must lie in 1..3");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic              wrap;
   logic [WORD_W-1:0] shd_q, act_q;
   logic [WORD_W-1:0] raw_word, fixed_word;
   logic              take_wr;

   phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .wrap(wrap)
   );

   // candidate word: whole write wins over a field write
   always_comb begin
      raw_word = shd_q;
      take_wr  = 1'b0;
      if (wr_en) begin
         raw_word = wr_word;
         take_wr  = 1'b1;
      end else if (fld_en && (int'(fld_sel) < NUM_DOM)) begin
         for (int d = 0; d < NUM_DOM; d++) begin
            if (int'(fld_sel) == d) raw_word[d*EXP_W +: EXP_W] = fld_exp;
         end
         take_wr = 1'b1;
      end
   end

   ratio_fix #(.EXP_W(EXP_W), .WORD_W(WORD_W)) u_fix (
      .raw_word(raw_word), .fixed_word(fixed_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_q <= '0;
         act_q <= '0;
      end else begin
         if (take_wr) shd_q <= fixed_word;
         if (wrap)    act_q <= shd_q;
      end
   end

   generate
      for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
         tick_gen #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_tick (
            .cnt(cnt_q),
            .exp_i(act_q[g*EXP_W +: EXP_W]),
            .en(dom_en[g]),
            .tick(dom_tick[g])
         );
      end
   endgenerate

   rate_unit #(.EXP_W(EXP_W), .WORD_W(WORD_W), .RATE_W(RATE_W)) u_rate (
      .parent_rate(parent_rate), .target_rate(target_rate),
      .act_word(act_q), .rate_sel(rate_sel),
      .hlp_exp(hlp_exp), .hlp_ok(hlp_ok), .rate_out(rate_out)
   );

   assign act_word = act_q;
   assign shd_word = shd_q;
endmodule

// File: rtl/pow2_div_bank_chk.sv
module pow2_div_bank_chk
   import pow2_div_pkg::*;
#(
   parameter int EXP_W  = 2,
   parameter int WORD_W = 16,
   parameter int RATE_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [(1<<EXP_W)-2:0] cnt,
   input logic [WORD_W-1:0]    act_word,
   input logic [NUM_DOM-1:0]   dom_en,
   input logic [NUM_DOM-1:0]   dom_tick,
   input logic [RATE_W-1:0]    parent_rate,
   input logic [RATE_W-1:0]    target_rate,
   input logic [EXP_W-1:0]     hlp_exp,
   input logic                 hlp_ok
);
   localparam int CNT_W = (1 << EXP_W) - 1;

   function automatic int fld(input logic [WORD_W-1:0] w, input int d);
      return int'(w[d*EXP_W +: EXP_W]);
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> ((dom_tick & dom_en) == dom_en));

   p_mmu_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fld(act_word, IDX_MMU) >= fld(act_word, IDX_SP) &&
      fld(act_word, IDX_MMU) <= fld(act_word, IDX_SP) + 1);

   p_tc_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (imax(fld(act_word, IDX_CORE), fld(act_word, IDX_MMU)) <=
       imin(fld(act_word, IDX_PER), fld(act_word, IDX_DISP)))
      |-> (fld(act_word, IDX_TC) >= fld(act_word, IDX_CORE) &&
           fld(act_word, IDX_TC) >= fld(act_word, IDX_MMU)));

   p_tc_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fld(act_word, IDX_TC) <= fld(act_word, IDX_DISP) &&
      fld(act_word, IDX_TC) <= fld(act_word, IDX_PER));

   p_commit_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(act_word)) |-> ($past(cnt) == {CNT_W{1'b1}}));

   p_count_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

   p_helper_fit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hlp_ok |-> ((parent_rate >> hlp_exp) <= target_rate));

   p_upper_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_word >> (NUM_DOM * EXP_W)) == '0);
endmodule

bind pow2_div_bank pow2_div_bank_chk #(
   .EXP_W(EXP_W), .WORD_W(WORD_W), .RATE_W(RATE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .act_word(act_word),
   .dom_en(dom_en), .dom_tick(dom_tick), .parent_rate(parent_rate),
   .target_rate(target_rate), .hlp_exp(hlp_exp), .hlp_ok(hlp_ok)
);

// File: tb/pow2_div_bank_test.sv
module pow2_div_bank_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_word = '0;
   logic        fld_en = 1'b0;
   logic [2:0]  fld_sel = '0;
   logic [1:0]  fld_exp = '0;
   logic [5:0]  dom_en = 6'h3f;
   logic [5:0]  dom_tick;
   logic [15:0] act_word, shd_word;
   logic [31:0] parent_rate = 32'd1000;
   logic [31:0] target_rate = 32'd300;
   logic [1:0]  hlp_exp;
   logic        hlp_ok;
   logic [2:0]  rate_sel = '0;
   logic [31:0] rate_out;

   int checks = 0;
   int failures = 0;
   bit run_chk = 1'b0;
   bit done = 1'b0;

   int          m_cnt = 0;
   logic [15:0] m_shd = '0;
   logic [15:0] m_act = '0;

   always #(CLK_P/2) clk = ~clk;

   pow2_div_bank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .fld_en(fld_en), .fld_sel(fld_sel), .fld_exp(fld_exp),
      .dom_en(dom_en), .dom_tick(dom_tick), .act_word(act_word),
      .shd_word(shd_word), .parent_rate(parent_rate),
      .target_rate(target_rate), .hlp_exp(hlp_exp), .hlp_ok(hlp_ok),
      .rate_sel(rate_sel), .rate_out(rate_out)
   );

   function automatic logic [15:0] fix(input logic [15:0] w);
      int e [6];
      logic [15:0] r;
      for (int d = 0; d < 6; d++) e[d] = int'((w >> (2*d)) & 16'h3);
      if (e[2] < e[1]) e[2] = e[1];
      if (e[2] > e[1] + 1) e[2] = e[1] + 1;
      if (e[3] < e[0]) e[3] = e[0];
      if (e[3] < e[2]) e[3] = e[2];
      if (e[3] > e[5]) e[3] = e[5];
      if (e[3] > e[4]) e[3] = e[4];
      r = '0;
      for (int d = 0; d < 6; d++) r = r | (16'(e[d]) << (2*d));
      return r;
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      logic [15:0] tmp;
      if (!rst_n) begin
         m_cnt = 0; m_shd = '0; m_act = '0;
      end else begin
         if (m_cnt == 7) m_act = m_shd;
         if (wr_en) m_shd = fix(wr_word);
         else if (fld_en && fld_sel < 3'd6) begin
            tmp = m_shd;
            tmp[fld_sel*2 +: 2] = fld_exp;
            m_shd = fix(tmp);
         end
         m_cnt = (m_cnt + 1) % 8;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison away from the clock edge
   always @(negedge clk) begin
      #1;
      if (rst_n && run_chk) begin
         logic [5:0] et;
         logic [1:0] he;
         logic       hk;
         logic [31:0] er;
         for (int d = 0; d < 6; d++) begin
            int e;
            e = int'((m_act >> (2*d)) & 16'h3);
            et[d] = dom_en[d] && ((m_cnt % (1 << e)) == 0);
         end
         hk = 1'b0; he = '0;
         for (int e = 3; e >= 0; e--) begin
            if ((parent_rate >> e) <= target_rate) begin hk = 1'b1; he = 2'(e); end
         end
         er = (rate_sel < 3'd6) ? (parent_rate >> ((m_act >> (2*rate_sel)) & 16'h3)) : 32'd0;
         chk("R2/R8 tick", 32'(dom_tick), 32'(et));
         chk("R7 active word", 32'(act_word), 32'(m_act));
         chk("R3/R4/R5/R6 shadow word", 32'(shd_word), 32'(m_shd));
         chk("R9 helper ok", 32'(hlp_ok), 32'(hk));
         if (hk) chk("R9 helper exponent", 32'(hlp_exp), 32'(he));
         chk("R10 rate report", rate_out, er);
      end
   end

   task automatic put_word(input logic [15:0] w);
      @(negedge clk); wr_en = 1'b1; wr_word = w;
      @(negedge clk); wr_en = 1'b0;
      #2;
   endtask

   task automatic put_field(input logic [2:0] s, input logic [1:0] e);
      @(negedge clk); fld_en = 1'b1; fld_sel = s; fld_exp = e;
      @(negedge clk); fld_en = 1'b0;
      #2;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1; #2;
      chk("R1 active word after reset", 32'(act_word), 32'h0);
      chk("R1 shadow word after reset", 32'(shd_word), 32'h0);
      chk("R1 all enabled ticks at counter zero", 32'(dom_tick), 32'h3f);
      run_chk = 1'b1;

      put_word(16'h0F32);
      chk("R3 clamp memory exponent and R4 raise traffic", 32'(shd_word), 32'h0F92);
      put_word(16'h0703);
      chk("R5 ceiling wins over core floor", 32'(shd_word), 32'h0743);
      idle(9);
      chk("R7 committed after wrap", 32'(act_word), 32'h0743);
      rate_sel = 3'd5; #1;
      chk("R10 display rate", rate_out, 32'd500);
      rate_sel = 3'd0; #1;
      chk("R10 core rate", rate_out, 32'd125);
      rate_sel = 3'd6; #1;
      chk("R10 unused select", rate_out, 32'd0);

      put_field(3'd5, 2'd3);
      chk("R6 field write then correction", 32'(shd_word), 32'h0FC3);
      put_field(3'd6, 2'd1);
      chk("R6 out-of-range select ignored", 32'(shd_word), 32'h0FC3);
      @(negedge clk); wr_en = 1'b1; wr_word = 16'h0000; fld_en = 1'b1; fld_sel = 3'd1; fld_exp = 2'd2;
      @(negedge clk); wr_en = 1'b0; fld_en = 1'b0; #2;
      chk("R6 whole write has priority", 32'(shd_word), 32'h0000);

      put_word(16'hF555);
      chk("R11 upper bits dropped", 32'(shd_word[15:12]), 32'h0);

      parent_rate = 32'd1000; target_rate = 32'd300; #1;
      chk("R9 exponent for 300", 32'(hlp_exp), 32'd2);
      target_rate = 32'd100; #1;
      chk("R9 unreachable target", 32'(hlp_ok), 32'd0);
      target_rate = 32'd1000; #1;
      chk("R9 exact fit", 32'(hlp_exp), 32'd0);
      target_rate = 32'd999; #1;
      chk("R9 just below parent", 32'(hlp_exp), 32'd1);
      target_rate = 32'd300;

      put_word(16'h0E94);
      idle(10);
      @(negedge clk); dom_en = 6'b000000; #2;
      chk("R8 disabled domains stay low", 32'(dom_tick), 32'h0);
      idle(5);
      chk("R8 disabled domains stay low later", 32'(dom_tick), 32'h0);
      @(negedge clk); dom_en = 6'b010101;
      idle(13);
      @(negedge clk); dom_en = 6'h3f;
      idle(9);

      for (int ph = 0; ph < 8; ph++) begin
         idle(ph);
         put_word(16'((ph * 16'h1357) ^ 16'h2A6C));
         put_field(3'(ph % 6), 2'(ph));
         idle(3);
      end
      for (int s = 0; s < 8; s++) begin
         @(negedge clk); rate_sel = 3'(s);
         target_rate = 32'(s * 140);
      end
      idle(10);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule